// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block turns single access requests from a 16-bit core into timed external bus cycles. It drives an address latch enable, a code fetch strobe, a data read strobe and two byte-lane write strobes. It supports code reads, data reads and data writes. Each kind can run with or without an address latch phase, and each of these six variants takes its length from its own 2-bit field in two timing configuration words. Strobe width, setup and hold are derived from the programmed length by subtracting the latch, write pulse and hold allocations.

All timing is counted in ticks of `clk_i`, a timing clock that runs at twice the bus clock. One bus clock is two ticks, which gives half-clock resolution. The request fields and both configuration words are sampled on the edge that accepts a request. A 16-bit access on an 8-bit bus runs as two byte halves. The first half follows the requested latch option and the second half always runs without a latch phase. An active wait input stretches the strobe. The core holds `req_i` until it sees `ack_o`.

Top module: `bus_cyc_seq`

## Requirements
- R1: After reset every output is low, and they stay low until a request is accepted.
- R2: Code read: a field code c selects the length. With a latch phase the cycle lasts 2c+4 ticks (`tcfg_main_i[1:0]`); without one it lasts 2c+2 ticks (`tcfg_main_i[3:2]`). `req_kind_i` 00 selects a code read. In a latch cycle `code_stb_o` covers every tick that is left after the latch allocation; without a latch it covers the whole cycle.
- R3: Data read (`req_kind_i` 01, and 11 is handled the same way): a no-latch read lasts 2c+2 ticks (`tcfg_data_i[1:0]`) and a latch read lasts 2c+4 ticks (`tcfg_data_i[3:2]`). `rd_stb_o` is shaped as in R2.
- R4: `ale_o` is high for 1 tick when `tcfg_main_i[4]` is 0 and for 3 ticks when it is 1. One tick with no output active always follows it. `ale_o` never overlaps a strobe, and at most one strobe kind is active at a time.
- R5: Write (`req_kind_i` 10): the length is 2c+4 ticks (no latch: `tcfg_data_i[5:4]`, latch: `tcfg_data_i[7:6]`). The strobe is 2 ticks, or 4 ticks when `tcfg_main_i[5]` is 1. The hold is 0 ticks, or 2 ticks when `tcfg_main_i[6]` is 1. The setup before the strobe is the length minus strobe minus hold, minus the latch allocation (latch width plus one tick) in a latch cycle.
- R6: Write lane selection. On a 16-bit bus (`bus16_i`=1), a 16-bit write drives both `wr_lo_o` and `wr_hi_o`. A byte write with `req_hi_i`=1 drives only `wr_hi_o`, and one with `req_hi_i`=0 drives only `wr_lo_o`. On an 8-bit bus only `wr_lo_o` is used.
- R7: `hold_err_o` pulses for the first tick of any accepted write whose `tcfg_main_i[6]` is 0. The write still runs.
- R8: With `wait_i` high during the last tick of a strobe, that strobe repeats its last tick. A read strobe of only 2 ticks is never stretched. Code and write strobes can always be stretched.
- R9: A 16-bit access (`req_wide_i`=1) on an 8-bit bus runs two halves. The second half uses no-latch timing of the same kind, and `half2_o` is high for its whole duration. Read and code strobes stay high without a gap across the boundary.
- R10: If a read strobe comes out at zero ticks it runs as 2 ticks, and if a write setup comes out at zero or less it runs as 1 tick. In either case `cfg_err_o` pulses in the first tick of the access.
- R11: A request is accepted only while idle and with `ack_o` low. `ack_o` is a single-tick pulse in the tick right after the last active tick of the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock, two ticks per bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tcfg_main_i | input | 7 | Code lengths, latch width, write strobe and hold bits |
| tcfg_data_i | input | 8 | Data read and write length fields |
| bus16_i | input | 1 | External bus is 16 bits wide |
| req_i | input | 1 | Access request, held until acknowledge |
| req_kind_i | input | 2 | 00 code, 01 read, 10 write, 11 read |
| req_ale_i | input | 1 | Access starts with an address latch phase |
| req_wide_i | input | 1 | 16-bit access |
| req_hi_i | input | 1 | Byte access targets the upper byte |
| wait_i | input | 1 | Stretch the active strobe |
| ack_o | output | 1 | Access complete pulse |
| ale_o | output | 1 | Address latch enable |
| code_stb_o | output | 1 | Code fetch strobe, active high |
| rd_stb_o | output | 1 | Data read strobe, active high |
| wr_lo_o | output | 1 | Low byte write strobe, active high |
| wr_hi_o | output | 1 | High byte write strobe, active high |
| half2_o | output | 1 | Second half of a split access |
| cfg_err_o | output | 1 | Timing fields were clamped for this access |
| hold_err_o | output | 1 | Write accepted without extended hold |

## Verification
Every access is recorded tick by tick and compared with a waveform that the bench builds from the field values. Random configurations, kinds, widths and latch options cover all six length tables and both latch widths. Wait patterns of varying length are used to tell strobes that stretch apart from 2-tick read strobes that must not. Directed cases target the clamping corners, the lane choice for each bus width, and split reads. Split reads show whether the strobe stays continuous at the half boundary and whether the second half really drops the latch phase.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int MAX_CLK = 5;
  localparam int TICK_W  = $clog2(2*MAX_CLK+1);
  localparam int NHALF   = 2;
  localparam int MAIN_W  = 7;
  localparam int DATA_W  = 8;
  localparam int FLD_W   = 2;

  typedef enum logic [1:0] {
    K_CODE = 2'd0, K_READ = 2'd1, K_WRITE = 2'd2, K_READ_ALT = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ALE, PH_GAP, PH_SETUP, PH_STB, PH_HOLD
  } phase_e;

  typedef struct packed {
    logic              use_ale;
    logic              can_wait;
    logic              err;
    logic [TICK_W-1:0] ale_t;
    logic [TICK_W-1:0] setup_t;
    logic [TICK_W-1:0] stb_t;
    logic [TICK_W-1:0] hold_t;
  } half_t;
endpackage

// File: rtl/bus_seq_timing.sv
module bus_seq_timing
  import bus_seq_pkg::*;
(
  input  kind_e             kind_i,
  input  logic              ale_i,
  input  logic [MAIN_W-1:0] main_i,
  input  logic [DATA_W-1:0] data_i,
  output half_t             half_o
);
  logic [FLD_W-1:0] fld;
  logic is_wr, err;
  int total, ale_w, alloc, stb, hold, setup;

  always_comb begin
    is_wr = (kind_i == K_WRITE);
    case (kind_i)
      K_CODE:  fld = ale_i ? main_i[1:0] : main_i[3:2];
      K_WRITE: fld = ale_i ? data_i[7:6] : data_i[5:4];
      default: fld = ale_i ? data_i[3:2] : data_i[1:0];
    endcase
    total = 2*int'(fld) + ((ale_i || is_wr) ? 4 : 2);
    ale_w = main_i[4] ? 3 : 1;
    alloc = ale_i ? ale_w + 1 : 0;
    err   = 1'b0;
    if (is_wr) begin
      stb   = main_i[5] ? 4 : 2;
      hold  = main_i[6] ? 2 : 0;
      setup = total - stb - hold - alloc;
      if (setup < 1) begin
        setup = 1;
        err   = 1'b1;
      end
    end else begin
      hold  = 0;
      setup = 0;
      stb   = total - alloc;
      if (stb < 2) begin
        stb = 2;
        err = 1'b1;
      end
    end
    half_o.use_ale  = ale_i;
    // read strobes need a window one clock shorter than their width
    half_o.can_wait = is_wr || (kind_i == K_CODE) || (stb > 2);
    half_o.err      = err;
    half_o.ale_t    = TICK_W'(ale_w);
    half_o.setup_t  = TICK_W'(setup);
    half_o.stb_t    = TICK_W'(stb);
    half_o.hold_t   = TICK_W'(hold);
  end
endmodule

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  kind_e             kind_i,
  input  logic              wide_i,
  input  logic              hi_i,
  input  logic              bus16_i,
  input  logic              wait_i,
  input  logic              hold_bit_i,
  input  half_t [NHALF-1:0] hs_i,
  output logic              ack_o,
  output logic              ale_o,
  output logic              code_o,
  output logic              rd_o,
  output logic              wrl_o,
  output logic              wrh_o,
  output logic              half2_o,
  output logic              cerr_o,
  output logic              herr_o
);
  phase_e            st_q, st_d;
  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic              half_q, half_d;
  kind_e             kind_q, kind_d;
  logic              split_q, lo_q, hi_q;
  half_t [NHALF-1:0] hs_q;
  half_t             cur;
  logic              start, ack_d, end_half, is_wr;
  logic              split_new, lo_new, hi_new, lo_d, hi_d, stb_d;

  function automatic phase_e first_ph(half_t h, logic wr);
    if (h.use_ale) return PH_ALE;
    else if (wr)   return PH_SETUP;
    else           return PH_STB;
  endfunction

  function automatic logic [TICK_W-1:0] first_len(half_t h, logic wr);
    if (h.use_ale) return h.ale_t;
    else if (wr)   return h.setup_t;
    else           return h.stb_t;
  endfunction

  assign cur       = hs_q[half_q];
  assign is_wr     = (kind_q == K_WRITE);
  assign split_new = wide_i & ~bus16_i;
  assign lo_new    = ~bus16_i | wide_i | ~hi_i;
  assign hi_new    = bus16_i & (wide_i | hi_i);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    half_d   = half_q;
    ack_d    = 1'b0;
    start    = 1'b0;
    end_half = 1'b0;
    if (st_q == PH_IDLE) begin
      if (req_i && !ack_o) begin
        start  = 1'b1;
        half_d = 1'b0;
        st_d   = first_ph(hs_i[0], kind_i == K_WRITE);
        cnt_d  = first_len(hs_i[0], kind_i == K_WRITE);
      end
    end else if (cnt_q > 1) begin
      cnt_d = cnt_q - 1'b1;
    end else if (st_q == PH_STB && wait_i && cur.can_wait) begin
      cnt_d = cnt_q;
    end else begin
      case (st_q)
        PH_ALE: begin
          st_d  = PH_GAP;
          cnt_d = 1;
        end
        PH_GAP: begin
          st_d  = is_wr ? PH_SETUP : PH_STB;
          cnt_d = is_wr ? cur.setup_t : cur.stb_t;
        end
        PH_SETUP: begin
          st_d  = PH_STB;
          cnt_d = cur.stb_t;
        end
        PH_STB: begin
          if (is_wr && cur.hold_t != 0) begin
            st_d  = PH_HOLD;
            cnt_d = cur.hold_t;
          end else begin
            end_half = 1'b1;
          end
        end
        default: end_half = 1'b1;
      endcase
      if (end_half) begin
        if (split_q && !half_q) begin
          half_d = 1'b1;
          st_d   = first_ph(hs_q[1], is_wr);
          cnt_d  = first_len(hs_q[1], is_wr);
        end else begin
          half_d = 1'b0;
          st_d   = PH_IDLE;
          cnt_d  = '0;
          ack_d  = 1'b1;
        end
      end
    end
  end

  assign kind_d = start ? kind_i : kind_q;
  assign lo_d   = start ? lo_new : lo_q;
  assign hi_d   = start ? hi_new : hi_q;
  assign stb_d  = (st_d == PH_STB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PH_IDLE;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      kind_q  <= K_CODE;
      split_q <= 1'b0;
      lo_q    <= 1'b0;
      hi_q    <= 1'b0;
      hs_q    <= '0;
      ack_o   <= 1'b0;
      ale_o   <= 1'b0;
      code_o  <= 1'b0;
      rd_o    <= 1'b0;
      wrl_o   <= 1'b0;
      wrh_o   <= 1'b0;
      half2_o <= 1'b0;
      cerr_o  <= 1'b0;
      herr_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
      if (start) begin
        kind_q  <= kind_i;
        split_q <= split_new;
        lo_q    <= lo_new;
        hi_q    <= hi_new;
        hs_q    <= hs_i;
      end
      // outputs are flops fed from next-state decode
      ack_o   <= ack_d;
      ale_o   <= (st_d == PH_ALE);
      code_o  <= stb_d && (kind_d == K_CODE);
      rd_o    <= stb_d && (kind_d == K_READ || kind_d == K_READ_ALT);
      wrl_o   <= stb_d && (kind_d == K_WRITE) && lo_d;
      wrh_o   <= stb_d && (kind_d == K_WRITE) && hi_d;
      half2_o <= half_d;
      cerr_o  <= start && (hs_i[0].err || (split_new && hs_i[1].err));
      herr_o  <= start && (kind_i == K_WRITE) && !hold_bit_i;
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o) else $error("ack longer than one tick"); // R11
  AST_STB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ale_o, code_o, rd_o, wrl_o | wrh_o})) else $error("overlap"); // R4
  AST_ALE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> !(code_o || rd_o || wrl_o || wrh_o)) else $error("no gap"); // R4
  AST_RD_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_o || code_o) |-> ack_o) else $error("read strobe broke"); // R9
  AST_WR_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wrl_o || wrh_o) |=> (wrl_o || wrh_o)) else $error("short write"); // R5
  AST_HERR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    herr_o |=> !herr_o) else $error("hold flag not a pulse"); // R7
  AST_CERR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cerr_o |=> !cerr_o) else $error("cfg flag not a pulse"); // R10
endmodule

// File: rtl/bus_cyc_seq.sv
module bus_cyc_seq
  import bus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MAIN_W-1:0] tcfg_main_i,
  input  logic [DATA_W-1:0] tcfg_data_i,
  input  logic              bus16_i,
  input  logic              req_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_ale_i,
  input  logic              req_wide_i,
  input  logic              req_hi_i,
  input  logic              wait_i,
  output logic              ack_o,
  output logic              ale_o,
  output logic              code_stb_o,
  output logic              rd_stb_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic              half2_o,
  output logic              cfg_err_o,
  output logic              hold_err_o
);
  kind_e             kind;
  half_t [NHALF-1:0] half_live;

  assign kind = kind_e'(req_kind_i);

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    // only the first half may carry a latch phase
    bus_seq_timing u_tim (
      .kind_i (kind),
      .ale_i  ((g == 0) ? req_ale_i : 1'b0),
      .main_i (tcfg_main_i),
      .data_i (tcfg_data_i),
      .half_o (half_live[g])
    );
  end

  bus_seq_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .kind_i     (kind),
    .wide_i     (req_wide_i),
    .hi_i       (req_hi_i),
    .bus16_i    (bus16_i),
    .wait_i     (wait_i),
    .hold_bit_i (tcfg_main_i[6]),
    .hs_i       (half_live),
    .ack_o      (ack_o),
    .ale_o      (ale_o),
    .code_o     (code_stb_o),
    .rd_o       (rd_stb_o),
    .wrl_o      (wr_lo_o),
    .wrh_o      (wr_hi_o),
    .half2_o    (half2_o),
    .cerr_o     (cfg_err_o),
    .herr_o     (hold_err_o)
  );
endmodule

// File: tb/sim_bus_cyc_seq.sv
`timescale 1ns/1ps
module sim_bus_cyc_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] tmain = '0;
  logic [7:0] tdata = '0;
  logic bus16 = 1'b0, req = 1'b0, r_ale = 1'b0, r_wide = 1'b0, r_hi = 1'b0, wt = 1'b0;
  logic [1:0] r_kind = 2'd0;
  logic ack, ale, cstb, rstb, wlo, whi, h2, cerr, herr;
  int checks = 0, fails = 0;
  logic [7:0] exp_tr [0:127];
  logic [7:0] got_tr [0:127];
  int exp_n;

  always #2.5 clk = ~clk;

  bus_cyc_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .tcfg_main_i(tmain), .tcfg_data_i(tdata),
    .bus16_i(bus16), .req_i(req), .req_kind_i(r_kind), .req_ale_i(r_ale),
    .req_wide_i(r_wide), .req_hi_i(r_hi), .wait_i(wt), .ack_o(ack),
    .ale_o(ale), .code_stb_o(cstb), .rd_stb_o(rstb), .wr_lo_o(wlo),
    .wr_hi_o(whi), .half2_o(h2), .cfg_err_o(cerr), .hold_err_o(herr)
  );

  task automatic check(input bit ok, input string req_tag, input string what,
                       input int got, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req_tag, what, got, expv);
    end
  endtask

  task automatic emit(input logic [7:0] b);
    exp_tr[exp_n] = b;
    exp_n++;
  endtask

  // bits: ale rd code wrl wrh half2 cerr herr
  task automatic build_expect(input logic [1:0] kind, input logic a, input logic w,
                              input logic h, input logic b16, input int k);
    int halves, fld, tot, alw, alc, stb, hold, setup;
    logic ah, err, wr, okw;
    logic [7:0] sb;
    exp_n = 0;
    err = 1'b0;
    wr = (kind == 2'd2);
    halves = (w && !b16) ? 2 : 1;
    for (int hf = 0; hf < halves; hf++) begin
      ah = (hf == 0) ? a : 1'b0;
      if (kind == 2'd0)  fld = ah ? int'(tmain[1:0]) : int'(tmain[3:2]);
      else if (wr)       fld = ah ? int'(tdata[7:6]) : int'(tdata[5:4]);
      else               fld = ah ? int'(tdata[3:2]) : int'(tdata[1:0]);
      tot = 2*fld + ((ah || wr) ? 4 : 2);
      alw = tmain[4] ? 3 : 1;
      alc = ah ? alw + 1 : 0;
      if (wr) begin
        stb = tmain[5] ? 4 : 2;
        hold = tmain[6] ? 2 : 0;
        setup = tot - stb - hold - alc;
        if (setup < 1) begin setup = 1; err = 1'b1; end
        sb = {3'b000, (!b16 || w || !h), (b16 && (w || h)), 3'b000};
        okw = 1'b1;
      end else begin
        hold = 0;
        setup = 0;
        stb = tot - alc;
        if (stb < 2) begin stb = 2; err = 1'b1; end
        sb = (kind == 2'd0) ? 8'b0010_0000 : 8'b0100_0000;
        okw = (kind == 2'd0) || (stb > 2);
      end
      if (ah) begin
        for (int t = 0; t < alw; t++) emit(8'b1000_0000);
        emit(8'h00);
      end
      for (int t = 0; t < setup; t++) emit({5'b0, hf[0], 2'b0});
      for (int t = 0; t < stb; t++) begin
        emit(sb | {5'b0, hf[0], 2'b0});
        if (t == stb - 1)
          while (okw && (exp_n - 1) < k) emit(sb | {5'b0, hf[0], 2'b0});
      end
      for (int t = 0; t < hold; t++) emit({5'b0, hf[0], 2'b0});
    end
    exp_tr[0] = exp_tr[0] | {6'b0, err, (wr && !tmain[6])};
  endtask

  task automatic run_xact(input logic [1:0] kind, input logic a, input logic w,
                          input logic h, input logic b16, input int k,
                          input string tag);
    int ack_idx;
    int bad;
    build_expect(kind, a, w, h, b16, k);
    @(negedge clk);
    r_kind = kind; r_ale = a; r_wide = w; r_hi = h; bus16 = b16;
    req = 1'b1; wt = 1'b0;
    @(posedge clk);
    ack_idx = -1;
    for (int idx = 0; idx < 120; idx++) begin
      @(negedge clk);
      if (ack) begin ack_idx = idx; break; end
      got_tr[idx] = {ale, rstb, cstb, wlo, whi, h2, cerr, herr};
      wt = (idx < k);
    end
    req = 1'b0; wt = 1'b0;
    check(ack_idx == exp_n, "R11", "ack tick", ack_idx, exp_n);
    bad = -1;
    if (ack_idx == exp_n)
      for (int i = 0; i < exp_n; i++)
        if (bad < 0 && got_tr[i] !== exp_tr[i]) bad = i;
    check(bad < 0, tag, "trace bits",
          (bad < 0) ? 0 : int'(got_tr[bad]), (bad < 0) ? 0 : int'(exp_tr[bad]));
    @(negedge clk);
    check(!ack, "R11", "ack width", int'(ack), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check({ack, ale, cstb, rstb, wlo, whi, h2, cerr, herr} == 9'd0, "R1",
          "reset outputs", int'({ack, ale, cstb, rstb, wlo, whi, h2, cerr, herr}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({ack, ale, cstb, rstb, wlo, whi, h2} == 7'd0, "R1", "idle outputs",
          int'({ack, ale, cstb, rstb, wlo, whi, h2}), 0);

    // directed corners
    tmain = 7'b100_0110; tdata = 8'h1B;
    run_xact(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R2");
    run_xact(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 0, "R2");
    tmain = 7'b101_0110;
    run_xact(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R4");
    run_xact(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R3");
    run_xact(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 0, "R3");
    tmain = 7'b100_0000; tdata = 8'b0011_0000;
    run_xact(2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 0, "R6");
    run_xact(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 0, "R6");
    run_xact(2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 0, "R6");
    run_xact(2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R6");
    run_xact(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 0, "R5");
    tmain = 7'b000_0000;
    run_xact(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 0, "R7");
    tmain = 7'b101_0000; tdata = 8'b0000_0000;
    run_xact(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R10");
    tmain = 7'b111_0000;
    run_xact(2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R10");
    tmain = 7'b100_0000; tdata = 8'b0000_0000;
    run_xact(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3, "R8");
    run_xact(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3, "R8");
    tdata = 8'b0000_1001;
    run_xact(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R9");
    run_xact(2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R9");

    for (int n = 0; n < 200; n++) begin
      logic [1:0] kd;
      logic a, w, h, b16;
      int k;
      string tag;
      tmain = 7'($urandom);
      tdata = 8'($urandom);
      if ($urandom_range(0, 3) != 0) tmain[6] = 1'b1;
      kd = 2'($urandom);
      a = 1'($urandom); w = 1'($urandom); h = 1'($urandom); b16 = 1'($urandom);
      k = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 8)) : 0;
      if (k > 0)                tag = "R8";
      else if (w && !b16)       tag = "R9";
      else if (kd == 2'd2)      tag = "R5";
      else if (kd == 2'd0)      tag = "R2";
      else                      tag = "R3";
      run_xact(kd, a, w, h, b16, k, tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule